// File: doc/BRIEF.md
# Lazy FP Context Store Sequencer

This block writes a floating-point register context to a reserved stack frame only when the context is actually needed. Exception entry sets a "save pending" flag. The flag does not cause a store by itself. The store starts only when the core signals that an FP instruction is about to issue while that flag is set. The sequencer first checks whether the interrupted context was allowed to use the FPU. It then streams the single-precision registers and the FP status word to memory, one 32-bit word per write handshake. Each write carries the privilege level and the negative-priority indication of the interrupted context.

A failed permission check or a failed write ends the save and pends a fault. The `fault_take_i` input tells the block whether that fault can be taken at once. If it can, the sequence aborts: the pending flag stays set and the register file is not touched. If it cannot, the sequence completes: the flag is cleared and, in the treat-as-secure case, the FP registers and status word are cleared.

The state machine has six states. IDLE waits for `start_i`. On a start with the flag clear it goes to BYPASS. On a start with the flag set it latches the context bits and goes to CHECK. CHECK goes to RESOLVE when access is denied or the stack limit is violated, and otherwise to STORE_REG. STORE_REG goes to RESOLVE on a write error, to STORE_STAT after the last register word, and otherwise stays in STORE_REG and advances the word index. STORE_STAT goes to RESOLVE after its one write. RESOLVE and BYPASS each pulse `done_o` and return to IDLE.

Top module: `lfp_save_seq`

## Requirements
- R1: `lazy_arm_i` sets the pending flag shown on `lazy_pend_o`. A `start_i` while the flag is clear produces a single `done_o` pulse with no write, no fault, no abort and no clear. A completion without abort leaves `lazy_pend_o` low afterwards, so a later start takes this bypass path.
- R2: The save writes 16 register words, unless the context is secure (`ctx_secure_i`=1) and treat-as-secure (`ctx_ts_i`=1) are both set. In that case it writes 32 register words.
- R3: Register word k goes to base + 4k. For k ≥ 16, 8 more bytes are added. The status word (`fpscr_i`) is written last, at base + 0x40.
- R4: Registers are read as 64-bit pairs through `rf_idx_o` (pair k/2). Bits [31:0] of a pair are the even word and are written before bits [63:32], the odd word.
- R5: If `ctx_fpu_ok_i`=0, the block pends one fault with `fault_nocp_o`=1 in the context's own bank and makes no write. On `fault_bank_o`, 1 means secure and 0 means non-secure.
- R6: If the FPU is accessible but the context is non-secure and `ctx_ns_cp10_i`=0, the block pends one no-coprocessor fault with `fault_bank_o`=1 and makes no write.
- R7: If `ctx_splim_i`=1, the block makes no write and pends no fault. The outcome counts as a successful save.
- R8: A write whose handshake carries `mem_err_i`=1 pends one fault with `fault_stk_o`=1 in the context's bank. No further write is issued after it.
- R9: The sequence aborts when a fault was pended by the checks in R5, R6 or R8 and `fault_take_i`=1 during RESOLVE. On abort, `abort_o` is high with `done_o` and the flag stays set. In every other case `abort_o` is low and the flag is cleared.
- R10: `ctx_clear_o` pulses with `done_o` exactly when treat-as-secure applies (secure and ts) and the sequence did not abort.
- R11: Every write presents `mem_priv_o` = NOT `ctx_user_i` and `mem_negpri_o` = NOT `ctx_hfrdy_i`.
- R12: `mem_valid_o` holds with stable address and data until `mem_ready_i`. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lazy_arm_i | input | 1 | Sets the save-pending flag |
| start_i | input | 1 | FP instruction about to issue |
| done_o | output | 1 | Sequence finished (one cycle) |
| abort_o | output | 1 | Save abandoned, qualifies done_o |
| lazy_pend_o | output | 1 | Save-pending flag |
| ctx_secure_i | input | 1 | Saved context is secure |
| ctx_ts_i | input | 1 | Treat-as-secure bit |
| ctx_user_i | input | 1 | Saved context was unprivileged |
| ctx_hfrdy_i | input | 1 | Handler-ready bit (low means negative priority) |
| ctx_splim_i | input | 1 | Stack limit was violated |
| ctx_fpu_ok_i | input | 1 | Saved context had FPU access |
| ctx_ns_cp10_i | input | 1 | Non-secure FPU access enable |
| frame_base_i | input | ADDR_W | Frame base address |
| rf_idx_o | output | $clog2(NREG/2) | Register pair read index |
| rf_data_i | input | 2*DATA_W | Register pair read data |
| fpscr_i | input | DATA_W | FP status/control word |
| ctx_clear_o | output | 1 | Zero all FP registers and status word |
| mem_valid_o | output | 1 | Write request valid |
| mem_ready_i | input | 1 | Write accepted |
| mem_err_i | input | 1 | Accepted write failed |
| mem_addr_o | output | ADDR_W | Write address |
| mem_data_o | output | DATA_W | Write data |
| mem_priv_o | output | 1 | Write is privileged |
| mem_negpri_o | output | 1 | Write at negative priority |
| fault_pend_o | output | 1 | Pend a fault this cycle |
| fault_bank_o | output | 1 | Fault bank, 1 = secure |
| fault_nocp_o | output | 1 | Cause: no coprocessor access |
| fault_stk_o | output | 1 | Cause: stacking write failed |
| fault_take_i | input | 1 | Pended fault can be taken now |

## Verification
The assertions check these properties on every cycle: a stalled write holds its request, an error stops all further writes and leads straight to a done pulse, every fault carries exactly one cause, a no-coprocessor fault is never followed by a write, and the flag is kept or cleared as the abort bit dictates. The address and data order, the 16-versus-32 word count, the hole before the upper registers, the bank a fault goes to and the clear decision need known inputs to check. Only the bench's sweep over every combination of the context bits, the take-now input and the error position can show them.

// File: rtl/lfp_pkg.sv
package lfp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_STORE_REG,
        ST_STORE_STAT,
        ST_RESOLVE,
        ST_BYPASS
    } lfp_state_e;

    typedef struct packed {
        logic secure;
        logic ts;
        logic user;
        logic hfrdy;
        logic splim;
        logic fpu_ok;
        logic ns_cp10;
    } lfp_ctx_t;

endpackage

// File: rtl/lfp_access_chk.sv
module lfp_access_chk (
    input  logic secure_i,
    input  logic fpu_ok_i,
    input  logic ns_cp10_i,
    output logic deny_o,
    output logic bank_o
);
    // FPU access of the interrupted context is checked first; the
    // non-secure enable only matters once that passes.
    always_comb begin
        deny_o = !fpu_ok_i || (!secure_i && !ns_cp10_i);
        bank_o = fpu_ok_i ? 1'b1 : secure_i;
    end
endmodule

// File: rtl/lfp_addr_gen.sv
module lfp_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int NREG      = 32,
    parameter int BASE_REGS = 16
) (
    input  logic [ADDR_W-1:0]           base_i,
    input  logic [$clog2(NREG)-1:0]     widx_i,
    input  logic                        stat_sel_i,
    output logic [ADDR_W-1:0]           addr_o,
    output logic [$clog2(NREG/2)-1:0]   pair_o,
    output logic                        hi_o
);
    localparam int WIDX_W = $clog2(NREG);
    localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(4 * BASE_REGS);
    localparam logic [ADDR_W-1:0] GAP     = ADDR_W'(8);

    logic [ADDR_W-1:0] word_ofs;

    always_comb begin
        word_ofs = ADDR_W'(widx_i) << 2;
        if (widx_i >= WIDX_W'(BASE_REGS))
            word_ofs = word_ofs + GAP;
        addr_o = stat_sel_i ? (base_i + STAT_OFS) : (base_i + word_ofs);
        pair_o = widx_i[WIDX_W-1:1];
        hi_o   = widx_i[0];
    end
endmodule

// File: rtl/lfp_save_seq.sv
module lfp_save_seq
    import lfp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int NREG      = 32,
    parameter int BASE_REGS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lazy_arm_i,
    input  logic                        start_i,
    output logic                        done_o,
    output logic                        abort_o,
    output logic                        lazy_pend_o,
    input  logic                        ctx_secure_i,
    input  logic                        ctx_ts_i,
    input  logic                        ctx_user_i,
    input  logic                        ctx_hfrdy_i,
    input  logic                        ctx_splim_i,
    input  logic                        ctx_fpu_ok_i,
    input  logic                        ctx_ns_cp10_i,
    input  logic [ADDR_W-1:0]           frame_base_i,
    output logic [$clog2(NREG/2)-1:0]   rf_idx_o,
    input  logic [2*DATA_W-1:0]         rf_data_i,
    input  logic [DATA_W-1:0]           fpscr_i,
    output logic                        ctx_clear_o,
    output logic                        mem_valid_o,
    input  logic                        mem_ready_i,
    input  logic                        mem_err_i,
    output logic [ADDR_W-1:0]           mem_addr_o,
    output logic [DATA_W-1:0]           mem_data_o,
    output logic                        mem_priv_o,
    output logic                        mem_negpri_o,
    output logic                        fault_pend_o,
    output logic                        fault_bank_o,
    output logic                        fault_nocp_o,
    output logic                        fault_stk_o,
    input  logic                        fault_take_i
);
    localparam int WIDX_W = $clog2(NREG);
    localparam logic [WIDX_W-1:0] LAST_FULL = WIDX_W'(NREG - 1);
    localparam logic [WIDX_W-1:0] LAST_BASE = WIDX_W'(BASE_REGS - 1);

    lfp_state_e        state_q, state_d;
    lfp_ctx_t          ctx_q;
    logic [ADDR_W-1:0] base_q;
    logic [WIDX_W-1:0] widx_q;
    logic              ok_q;
    logic              pend_q;

    logic              ts_eff;
    logic              last_word;
    logic              deny;
    logic              deny_bank;
    logic              wr_fire;
    logic              hi_sel;
    logic              abort_now;

    lfp_access_chk u_access (
        .secure_i  (ctx_q.secure),
        .fpu_ok_i  (ctx_q.fpu_ok),
        .ns_cp10_i (ctx_q.ns_cp10),
        .deny_o    (deny),
        .bank_o    (deny_bank)
    );

    lfp_addr_gen #(
        .ADDR_W    (ADDR_W),
        .NREG      (NREG),
        .BASE_REGS (BASE_REGS)
    ) u_addr (
        .base_i     (base_q),
        .widx_i     (widx_q),
        .stat_sel_i (state_q == ST_STORE_STAT),
        .addr_o     (mem_addr_o),
        .pair_o     (rf_idx_o),
        .hi_o       (hi_sel)
    );

    assign ts_eff    = ctx_q.secure && ctx_q.ts;
    assign last_word = widx_q == (ts_eff ? LAST_FULL : LAST_BASE);
    assign wr_fire   = mem_valid_o && mem_ready_i;
    assign abort_now = (state_q == ST_RESOLVE) && !ok_q && fault_take_i;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (start_i) state_d = pend_q ? ST_CHECK : ST_BYPASS;
            ST_CHECK:
                if (deny || ctx_q.splim) state_d = ST_RESOLVE;
                else                     state_d = ST_STORE_REG;
            ST_STORE_REG:
                if (wr_fire) begin
                    if (mem_err_i)      state_d = ST_RESOLVE;
                    else if (last_word) state_d = ST_STORE_STAT;
                end
            ST_STORE_STAT:
                if (wr_fire) state_d = ST_RESOLVE;
            ST_RESOLVE:  state_d = ST_IDLE;
            ST_BYPASS:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            base_q  <= '0;
            widx_q  <= '0;
            ok_q    <= 1'b1;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                ctx_q  <= '{secure: ctx_secure_i, ts: ctx_ts_i, user: ctx_user_i,
                            hfrdy: ctx_hfrdy_i, splim: ctx_splim_i,
                            fpu_ok: ctx_fpu_ok_i, ns_cp10: ctx_ns_cp10_i};
                base_q <= frame_base_i;
                widx_q <= '0;
                ok_q   <= 1'b1;
            end
            if (state_q == ST_CHECK && deny)
                ok_q <= 1'b0;
            if (wr_fire && mem_err_i)
                ok_q <= 1'b0;
            if (state_q == ST_STORE_REG && wr_fire && !mem_err_i && !last_word)
                widx_q <= widx_q + 1'b1;
            if (lazy_arm_i)
                pend_q <= 1'b1;
            else if (state_q == ST_RESOLVE && !abort_now)
                pend_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        mem_valid_o  = (state_q == ST_STORE_REG) || (state_q == ST_STORE_STAT);
        mem_data_o   = (state_q == ST_STORE_STAT) ? fpscr_i
                     : (hi_sel ? rf_data_i[2*DATA_W-1:DATA_W] : rf_data_i[DATA_W-1:0]);
        mem_priv_o   = !ctx_q.user;
        mem_negpri_o = !ctx_q.hfrdy;
        fault_nocp_o = (state_q == ST_CHECK) && deny;
        fault_stk_o  = wr_fire && mem_err_i;
        fault_pend_o = fault_nocp_o || fault_stk_o;
        fault_bank_o = (state_q == ST_CHECK) ? deny_bank : ctx_q.secure;
        done_o       = (state_q == ST_RESOLVE) || (state_q == ST_BYPASS);
        abort_o      = abort_now;
        ctx_clear_o  = (state_q == ST_RESOLVE) && ts_eff && !abort_now;
        lazy_pend_o  = pend_q;
    end
endmodule

// File: rtl/lfp_save_seq_chk.sv
module lfp_save_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lazy_arm_i,
    input logic              done_o,
    input logic              abort_o,
    input logic              lazy_pend_o,
    input logic              ctx_clear_o,
    input logic              mem_valid_o,
    input logic              mem_ready_i,
    input logic              mem_err_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_data_o,
    input logic              fault_pend_o,
    input logic              fault_nocp_o,
    input logic              fault_stk_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R12
    AST_STOP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && mem_ready_i && mem_err_i |=> !mem_valid_o && done_o); // R8
    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pend_o |-> $countones({fault_nocp_o, fault_stk_o}) == 1); // R5
    AST_NOCP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_nocp_o |=> !mem_valid_o); // R5
    AST_ABORT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> done_o && !ctx_clear_o); // R9
    AST_KEEP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && abort_o |=> lazy_pend_o); // R9
    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !abort_o && !lazy_arm_i |=> !lazy_pend_o); // R1
    AST_CLEAR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear_o |-> done_o); // R10
endmodule

bind lfp_save_seq lfp_save_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lazy_arm_i   (lazy_arm_i),
    .done_o       (done_o),
    .abort_o      (abort_o),
    .lazy_pend_o  (lazy_pend_o),
    .ctx_clear_o  (ctx_clear_o),
    .mem_valid_o  (mem_valid_o),
    .mem_ready_i  (mem_ready_i),
    .mem_err_i    (mem_err_i),
    .mem_addr_o   (mem_addr_o),
    .mem_data_o   (mem_data_o),
    .fault_pend_o (fault_pend_o),
    .fault_nocp_o (fault_nocp_o),
    .fault_stk_o  (fault_stk_o)
);

// File: tb/lfp_save_seq_tb.sv
`timescale 1ns/1ps
module lfp_save_seq_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam logic [31:0] BASE  = 32'h2000_1000;
    localparam logic [31:0] FPSCR = 32'hF5C0_0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lazy_arm_i = 1'b0, start_i = 1'b0;
    logic done_o, abort_o, lazy_pend_o, ctx_clear_o;
    logic sec_i = 0, ts_i = 0, usr_i = 0, hfr_i = 1, spl_i = 0, fok_i = 1, ncp_i = 1;
    logic [3:0]    rf_idx_o;
    logic [63:0]   rf_data_i;
    logic mem_valid_o, mem_ready_i = 0, mem_err_i = 0, mem_priv_o, mem_negpri_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_data_o;
    logic fault_pend_o, fault_bank_o, fault_nocp_o, fault_stk_o;
    logic take_i = 0;

    int n_tests = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rf_data_i = {32'h1000_0000 + 32'(2 * rf_idx_o + 1), 32'h1000_0000 + 32'(2 * rf_idx_o)};

    lfp_save_seq u_dut (
        .clk(clk), .rst_n(rst_n), .lazy_arm_i(lazy_arm_i), .start_i(start_i),
        .done_o(done_o), .abort_o(abort_o), .lazy_pend_o(lazy_pend_o),
        .ctx_secure_i(sec_i), .ctx_ts_i(ts_i), .ctx_user_i(usr_i), .ctx_hfrdy_i(hfr_i),
        .ctx_splim_i(spl_i), .ctx_fpu_ok_i(fok_i), .ctx_ns_cp10_i(ncp_i),
        .frame_base_i(BASE), .rf_idx_o(rf_idx_o), .rf_data_i(rf_data_i), .fpscr_i(FPSCR),
        .ctx_clear_o(ctx_clear_o), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
        .mem_err_i(mem_err_i), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
        .mem_priv_o(mem_priv_o), .mem_negpri_o(mem_negpri_o), .fault_pend_o(fault_pend_o),
        .fault_bank_o(fault_bank_o), .fault_nocp_o(fault_nocp_o), .fault_stk_o(fault_stk_o),
        .fault_take_i(take_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input int k, input int n);
        if (k == n) return BASE + 32'h40;
        return BASE + 32'(4 * k) + (k >= 16 ? 32'd8 : 32'd0);
    endfunction

    task automatic run_case(input bit sec, input bit ts, input bit usr, input bit hfr,
                            input bit spl, input bit fok, input bit ncp, input bit take,
                            input int err_at, input bit arm);
        bit tse   = sec && ts;
        int n     = tse ? 32 : 16;
        bit deny  = !fok || (!sec && !ncp);
        bit dbank = !fok ? sec : 1'b1;
        bit errhit = arm && !deny && !spl && err_at >= 0 && err_at <= n;
        int exp_wr = (!arm || deny || spl) ? 0 : (errhit ? err_at + 1 : n + 1);
        bit ok    = !(arm && deny) && !errhit;
        bit eab   = arm && !ok && take;
        bit eclr  = arm && tse && !eab;
        int nw = 0, nf = 0, it = 0;
        bit f_bank = 0, f_nocp = 0, f_stk = 0;
        bit pv = 0, pr = 0;
        logic [31:0] pa = 0;
        @(negedge clk);
        sec_i = sec; ts_i = ts; usr_i = usr; hfr_i = hfr; spl_i = spl;
        fok_i = fok; ncp_i = ncp; take_i = take;
        if (arm) begin
            lazy_arm_i = 1; @(negedge clk); lazy_arm_i = 0;
            @(negedge clk);
            chk("R1 flag set by arm", 32'(lazy_pend_o), 32'(1));
        end
        start_i = 1; @(negedge clk); start_i = 0;
        while (!done_o && it < 300) begin
            if (pv && !pr) chk("R12 address held while stalled", mem_addr_o, pa);
            mem_ready_i = ((cyc % 3) != 1);
            mem_err_i   = mem_valid_o && mem_ready_i && (nw == err_at);
            #1;
            if (fault_pend_o) begin
                nf++; f_bank = fault_bank_o; f_nocp = fault_nocp_o; f_stk = fault_stk_o;
            end
            if (mem_valid_o && mem_ready_i) begin
                chk("R3 write address", mem_addr_o, exp_addr(nw, n));
                chk("R4 write data order", mem_data_o,
                    nw == n ? FPSCR : 32'h1000_0000 + 32'(nw));
                chk("R11 privilege", 32'({mem_priv_o, mem_negpri_o}), 32'({!usr, !hfr}));
                nw++;
            end
            pv = mem_valid_o; pr = mem_ready_i; pa = mem_addr_o;
            @(negedge clk);
            it++;
        end
        mem_ready_i = 0; mem_err_i = 0;
        chk("R12 done reached", 32'(done_o), 32'(1));
        chk("R2 write count", 32'(nw), 32'(exp_wr));
        chk("R9 abort", 32'(abort_o), 32'(eab));
        chk("R10 context clear", 32'(ctx_clear_o), 32'(eclr));
        if (arm && deny) begin
            chk("R5 nocp fault count", 32'(nf), 32'(1));
            chk("R6 fault bank and cause", 32'({f_bank, f_nocp, f_stk}), 32'({dbank, 2'b10}));
        end else if (errhit) begin
            chk("R8 stack fault count", 32'(nf), 32'(1));
            chk("R8 fault bank and cause", 32'({f_bank, f_nocp, f_stk}), 32'({sec, 2'b01}));
        end else begin
            chk("R7 no fault", 32'(nf), 32'(0));
        end
        @(negedge clk);
        chk("R12 done one cycle", 32'(done_o), 32'(0));
        chk("R9 flag after done", 32'(lazy_pend_o), 32'(eab));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R12 reset done low", 32'(done_o), 32'(0));
        chk("R12 reset valid low", 32'(mem_valid_o), 32'(0));
        chk("R1 reset flag low", 32'(lazy_pend_o), 32'(0));
        chk("R5 reset no fault", 32'(fault_pend_o), 32'(0));
        // R1: start with the flag clear is a bypass
        run_case(1, 1, 0, 1, 0, 1, 1, 0, -1, 0);
        for (int e = 0; e < 4; e++)
            for (int m = 0; m < 64; m++) begin
                bit s  = m[0], t = m[1], fo = m[2], nc = m[3], sp = m[4], tk = m[5];
                int ea = (e == 0) ? -1 : (e == 1) ? 0 : (e == 2) ? 17 : ((s && t) ? 32 : 16);
                run_case(s, t, m[0] ^ m[2], m[1] ^ m[3], sp, fo, nc, tk, ea, 1);
                if (tk) run_case(s, t, 0, 1, 0, 1, 1, 0, -1, 1); // clears any kept flag
            end
        // R1: after a clean save, a later start bypasses
        run_case(0, 0, 1, 0, 0, 1, 1, 0, -1, 1);
        run_case(0, 0, 1, 0, 0, 1, 1, 0, -1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule